// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command interpreter in front of a parallel NOR-style flash with a 16-bit data bus. It watches host write cycles, each carrying a word address and a data word. It decodes only the low data byte, and matches the cycles against guarded unlock sequences. A program request is accepted only after three command cycles followed by the program cycle itself. An erase request is accepted only after six command cycles. Other three-cycle sequences switch the read source between the memory array, the identification words and the query table, or return it to the array.

Its outputs are:

- **Read source select** (`rd_src`): tells the surrounding read path which source to return.
- **Identification word** (`id_word`): the value of the addressed identification register.
- **Start strobes**: one-cycle pulses, with the target address and data, that launch the array's program and erase engines.
- **Busy flag**: covers the internal operation time. New commands are ignored while it is high.

An active-low hardware reset pin is qualified by a minimum pulse width. A qualified pulse aborts whatever is in flight and returns the block to array reads. After the pin is released, a read hold-off window follows.

The write strobe is a plain per-cycle enable with no back-pressure. A write offered while it would be ignored (busy, hold-off, reset low) is dropped, not stalled. The host is expected to watch `busy` and `rd_hold` before issuing commands.

Top module: `flash_cmd_ctrl`

## Requirements

Command cycles use word addresses compared on their low 11 bits: 555h is called A1 and 2AAh is called A2. The unlock pair is AAh at A1 followed by 55h at A2. Only `wr_data[7:0]` is decoded in command cycles.

- R1: After the unlock pair and A0h at A1, the next accepted write raises `prog_start` for exactly one cycle, the cycle after that write. `prog_addr` and `prog_data` carry that write's full address and full 16-bit data.
- R2: After the unlock pair, 80h at A1, and a second unlock pair, a final write of 30h raises `erase_start` with `erase_chip`=0 and `erase_addr` set to that write's address. A final write of 10h at A1 raises `erase_start` with `erase_chip`=1. At most one start strobe is high in any cycle.
- R3: A write that breaks a partial sequence discards that sequence, returns `rd_src` to 0 (array) and starts no operation. A non-matching write outside a sequence changes nothing, except that a lone F0h selects the array.
- R4: `wr_data[15:8]` has no effect on command decoding.
- R5: The unlock pair followed by 90h selects the identification source (`rd_src`=1). In that mode `id_word` is 00BFh at `rd_addr` 0, 2761h at `rd_addr` 1 and 0000h elsewhere. `id_word` is 0000h in every other mode.
- R6: The unlock pair followed by 98h selects the query source (`rd_src`=2).
- R7: The unlock pair followed by F0h, or a single F0h write outside a sequence, selects the array (`rd_src`=0).
- R8: `busy` rises in the cycle of a start strobe. It stays high for PROG_CYC, SECT_CYC or CHIP_CYC cycles for a program, sector erase or chip erase respectively. While `busy` is high every write is ignored, including exit commands, so `rd_src` and the start strobes do not change.
- R9: `hw_rst_n` sampled low on RST_MIN consecutive clock edges aborts the sequence, clears `busy` and selects the array. A shorter low pulse has no effect on state.
- R10: From the qualifying edge of a reset pulse until REC_CYC cycles after the first edge that samples `hw_rst_n` high again, `rd_hold` is high and writes are ignored. An aborted erase is not resumed.
- R11: `rd_src` encodes 0 = array, 1 = identification, 2 = query, and never takes the value 3.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| hw_rst_n | input | 1 | Active-low hardware reset pin, width-qualified |
| wr_en | input | 1 | Host write cycle present this clock |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 16 | Write data word |
| rd_addr | input | ADDR_W | Read word address for the identification words |
| rd_src | output | 2 | Read source select: 0 array, 1 identification, 2 query |
| id_word | output | 16 | Identification word at `rd_addr` |
| rd_hold | output | 1 | Reads not yet valid after a hardware reset |
| busy | output | 1 | Internal program or erase in progress |
| prog_start | output | 1 | One-cycle program launch |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 16 | Program data word |
| erase_start | output | 1 | One-cycle erase launch |
| erase_chip | output | 1 | Erase scope: 1 whole chip, 0 sector |
| erase_addr | output | ADDR_W | Sector address of the erase |

## Verification

- **Write-driven outputs.** Mode changes and start strobes appear in the cycle after the rising edge that samples the write. `busy` rises in that same cycle and stays high for exactly the configured count.
- **Reset-driven outputs.** The hardware-reset abort takes effect on the RST_MIN-th consecutive edge that samples the pin low. `rd_hold` then stays high until REC_CYC cycles after the release edge.
- **Combinational output.** `id_word` follows `rd_addr` within the same cycle.
- **How the bench checks.** A behavioural model is advanced at each rising edge from the same sampled inputs. Every output is compared with it at the falling edge. Stimulus changes just after the falling edge, so each result is checked in the exact cycle it is due and not a cycle later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_IDENT = 2'd1,
    SRC_QUERY = 2'd2
  } rd_src_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERA3,
    SQ_ERA4,
    SQ_ERA5
  } seq_e;

  typedef struct packed {
    logic go_prog;
    logic go_erase;
    logic chip;
  } op_req_t;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_EXIT   = 8'hF0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;

  localparam logic [11:0] KEY_ADR_A = 12'h555;
  localparam logic [11:0] KEY_ADR_B = 12'h2AA;

  localparam logic [15:0] ID_WORD_MFR = 16'h00BF;
  localparam logic [15:0] ID_WORD_DEV = 16'h2761;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              wr_acc,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output op_req_t           req,
  output logic [1:0]        rd_src,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data,
  output logic              erase_start,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr
);

  localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(KEY_ADR_A);
  localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(KEY_ADR_B);

  seq_e    seq_q, seq_nx;
  rd_src_e mode_q, mode_nx;

  logic [7:0] cmd;
  logic       at_a, at_b;
  logic       key_a, key_b;

  // only the low byte is decoded; the upper byte only travels as program data
  assign cmd   = wr_data[7:0];
  assign at_a  = (wr_addr[CMD_AW-1:0] == ADR_A);
  assign at_b  = (wr_addr[CMD_AW-1:0] == ADR_B);
  assign key_a = at_a && (cmd == CMD_KEY_A);
  assign key_b = at_b && (cmd == CMD_KEY_B);

  always_comb begin
    seq_nx  = seq_q;
    mode_nx = mode_q;
    req     = '0;
    if (wr_acc) begin
      unique case (seq_q)
        SQ_IDLE: begin
          if (key_a)                seq_nx  = SQ_UNL1;
          else if (cmd == CMD_EXIT) mode_nx = SRC_ARRAY;
        end
        SQ_UNL1: begin
          if (key_b) seq_nx = SQ_UNL2;
          else begin
            seq_nx  = SQ_IDLE;
            mode_nx = SRC_ARRAY;
          end
        end
        SQ_UNL2: begin
          seq_nx = SQ_IDLE;
          unique case (cmd)
            CMD_PROG:  seq_nx  = SQ_PGM;
            CMD_ERASE: seq_nx  = SQ_ERA3;
            CMD_IDENT: mode_nx = SRC_IDENT;
            CMD_QUERY: mode_nx = SRC_QUERY;
            default:   mode_nx = SRC_ARRAY;
          endcase
        end
        SQ_PGM: begin
          seq_nx      = SQ_IDLE;
          req.go_prog = 1'b1;
        end
        SQ_ERA3, SQ_ERA4: begin
          if ((seq_q == SQ_ERA3) ? key_a : key_b)
            seq_nx = (seq_q == SQ_ERA3) ? SQ_ERA4 : SQ_ERA5;
          else begin
            seq_nx  = SQ_IDLE;
            mode_nx = SRC_ARRAY;
          end
        end
        SQ_ERA5: begin
          seq_nx = SQ_IDLE;
          if (cmd == CMD_SECTOR) begin
            req.go_erase = 1'b1;
          end else if (cmd == CMD_CHIP && at_a) begin
            req.go_erase = 1'b1;
            req.chip     = 1'b1;
          end else begin
            mode_nx = SRC_ARRAY;
          end
        end
        default: begin
          seq_nx  = SQ_IDLE;
          mode_nx = SRC_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q       <= SQ_IDLE;
      mode_q      <= SRC_ARRAY;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      erase_chip  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      erase_addr  <= '0;
    end else if (abort) begin
      seq_q       <= SQ_IDLE;
      mode_q      <= SRC_ARRAY;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      seq_q       <= seq_nx;
      mode_q      <= mode_nx;
      prog_start  <= req.go_prog;
      erase_start <= req.go_erase;
      if (req.go_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (req.go_erase) begin
        erase_addr <= wr_addr;
        erase_chip <= req.chip;
      end
    end
  end

  assign rd_src = mode_q;

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 20,
  parameter int CHIP_CYC = 40
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    abort,
  input  op_req_t req,
  output logic    busy
);

  localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C  = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    if (req.go_prog)   load_val = CNT_W'(PROG_CYC);
    else if (req.chip) load_val = CNT_W'(CHIP_CYC);
    else               load_val = CNT_W'(SECT_CYC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || abort)                remain_q <= '0;
    else if (req.go_prog || req.go_erase) remain_q <= load_val;
    else if (remain_q != '0)            remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);

endmodule

// File: rtl/flash_rst_guard.sv
module flash_rst_guard #(
  parameter int RST_MIN = 4,
  parameter int REC_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst_n,
  output logic abort,
  output logic rd_hold
);

  localparam int LW = $clog2(RST_MIN + 1);
  localparam int RW = $clog2(REC_CYC + 1);

  logic [LW-1:0] low_q;
  logic [RW-1:0] rec_q;
  logic          held_q;
  logic          release_ev;

  assign abort      = !hw_rst_n && (low_q == LW'(RST_MIN - 1));
  assign release_ev = hw_rst_n && held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      held_q <= 1'b0;
      rec_q  <= '0;
    end else begin
      if (!hw_rst_n) begin
        if (low_q != LW'(RST_MIN)) low_q <= low_q + 1'b1;
      end else begin
        low_q <= '0;
      end

      if (abort)           held_q <= 1'b1;
      else if (release_ev) held_q <= 1'b0;

      if (release_ev)         rec_q <= RW'(REC_CYC);
      else if (rec_q != '0)   rec_q <= rec_q - 1'b1;
    end
  end

  assign rd_hold = held_q || (rec_q != '0);

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [1:0]        rd_src,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       id_word
);

  always_comb begin
    id_word = 16'h0000;
    if (rd_src == SRC_IDENT) begin
      if (rd_addr == ADDR_W'(0))      id_word = ID_WORD_MFR;
      else if (rd_addr == ADDR_W'(1)) id_word = ID_WORD_DEV;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CMD_AW   = 11,
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 20,
  parameter int CHIP_CYC = 40,
  parameter int RST_MIN  = 4,
  parameter int REC_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_src,
  output logic [15:0]       id_word,
  output logic              rd_hold,
  output logic              busy,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data,
  output logic              erase_start,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr
);

  logic    abort;
  logic    wr_acc;
  op_req_t req;

  // a write counts only with the pin high, outside hold-off, and when idle
  assign wr_acc = wr_en && hw_rst_n && !rd_hold && !busy;

  flash_rst_guard #(
    .RST_MIN (RST_MIN),
    .REC_CYC (REC_CYC)
  ) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_rst_n (hw_rst_n),
    .abort    (abort),
    .rd_hold  (rd_hold)
  );

  flash_seq_fsm #(
    .ADDR_W (ADDR_W),
    .CMD_AW (CMD_AW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort       (abort),
    .wr_acc      (wr_acc),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .req         (req),
    .rd_src      (rd_src),
    .prog_start  (prog_start),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .erase_start (erase_start),
    .erase_chip  (erase_chip),
    .erase_addr  (erase_addr)
  );

  flash_op_timer #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (abort),
    .req   (req),
    .busy  (busy)
  );

  flash_id_rom #(
    .ADDR_W (ADDR_W)
  ) u_rom (
    .rd_src  (rd_src),
    .rd_addr (rd_addr),
    .id_word (id_word)
  );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_rst_n,
  input logic [1:0]        rd_src,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [15:0]       id_word,
  input logic              rd_hold,
  input logic              busy,
  input logic              prog_start,
  input logic              erase_start
);

  assert_start_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start}));

  assert_no_start_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> !$past(busy));

  assert_busy_rise_has_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (prog_start || erase_start));

  assert_src_frozen_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_src));

  assert_src_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src != 2'd3);

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_hold) && $past(!hw_rst_n)) |-> (!busy && rd_src == 2'd0));

  assert_no_start_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold |-> !(prog_start || erase_start));

  assert_ident_mfr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src == 2'd1 && rd_addr == '0) |-> id_word == 16'h00BF);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_rst_n    (hw_rst_n),
  .rd_src      (rd_src),
  .rd_addr     (rd_addr),
  .id_word     (id_word),
  .rd_hold     (rd_hold),
  .busy        (busy),
  .prog_start  (prog_start),
  .erase_start (erase_start)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW     = 20;
  localparam int P_PROG = 8;
  localparam int P_SECT = 20;
  localparam int P_CHIP = 40;
  localparam int P_RMIN = 4;
  localparam int P_REC  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_rst_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_src;
  logic [15:0]   id_word;
  logic          rd_hold, busy, prog_start, erase_start, erase_chip;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [15:0]   prog_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(
    .ADDR_W(AW), .CMD_AW(11), .PROG_CYC(P_PROG), .SECT_CYC(P_SECT),
    .CHIP_CYC(P_CHIP), .RST_MIN(P_RMIN), .REC_CYC(P_REC)
  ) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_src(rd_src), .id_word(id_word), .rd_hold(rd_hold), .busy(busy),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_chip(erase_chip), .erase_addr(erase_addr)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string ph      = "R11";

  // behavioural reference state
  int m_seq = 0, m_mode = 0, m_busy = 0, m_low = 0, m_held = 0, m_rec = 0;
  int m_ps = 0, m_es = 0, m_chip = 0;
  int unsigned m_paddr = 0, m_pdata = 0, m_eaddr = 0;

  always @(posedge clk) begin
    int unsigned a, lb;
    bit abrt, acc, go;
    if (!rst_n) begin
      m_seq = 0; m_mode = 0; m_busy = 0; m_low = 0; m_held = 0; m_rec = 0;
      m_ps = 0; m_es = 0;
    end else begin
      a    = wr_addr & 20'h7FF;
      lb   = wr_data & 16'h00FF;
      abrt = !hw_rst_n && (m_low == P_RMIN - 1);
      acc  = wr_en && hw_rst_n && (m_held == 0) && (m_rec == 0) && (m_busy == 0);
      go   = 0;
      m_ps = 0; m_es = 0;
      if (m_busy > 0) m_busy--;
      if (acc) begin
        case (m_seq)
          0: if (lb == 'hAA && a == 'h555) m_seq = 1;
             else if (lb == 'hF0) m_mode = 0;
          1: if (lb == 'h55 && a == 'h2AA) m_seq = 2;
             else begin m_seq = 0; m_mode = 0; end
          2: begin
               m_seq = 0;
               if (lb == 'hA0) m_seq = 3;
               else if (lb == 'h80) m_seq = 4;
               else if (lb == 'h90) m_mode = 1;
               else if (lb == 'h98) m_mode = 2;
               else m_mode = 0;
             end
          3: begin
               m_seq = 0; m_ps = 1; m_paddr = wr_addr; m_pdata = wr_data;
               m_busy = P_PROG;
             end
          4: if (lb == 'hAA && a == 'h555) m_seq = 5;
             else begin m_seq = 0; m_mode = 0; end
          5: if (lb == 'h55 && a == 'h2AA) m_seq = 6;
             else begin m_seq = 0; m_mode = 0; end
          default: begin
               m_seq = 0;
               if (lb == 'h30) begin
                 m_es = 1; m_chip = 0; m_eaddr = wr_addr; m_busy = P_SECT;
               end else if (lb == 'h10 && a == 'h555) begin
                 m_es = 1; m_chip = 1; m_eaddr = wr_addr; m_busy = P_CHIP;
               end else m_mode = 0;
             end
        endcase
      end
      if (abrt) begin
        m_seq = 0; m_mode = 0; m_busy = 0; m_ps = 0; m_es = 0;
      end
      if (!hw_rst_n) begin
        if (m_low < P_RMIN) m_low++;
      end else m_low = 0;
      if (abrt) m_held = 1;
      if (hw_rst_n && m_held == 1 && !go) begin
        m_held = 0; m_rec = P_REC;
      end else if (m_rec > 0) m_rec--;
    end
  end

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", ph, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_id(int mode, logic [AW-1:0] ra);
    if (mode != 1) return 16'h0000;
    if (ra == 0) return 16'h00BF;
    if (ra == 1) return 16'h2761;
    return 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      chk(rd_src == 2'(m_mode), "rd_src", 32'(rd_src), 32'(m_mode));
      chk(busy == (m_busy != 0), "busy", 32'(busy), 32'(m_busy != 0));
      chk(rd_hold == (m_held != 0 || m_rec != 0), "rd_hold",
          32'(rd_hold), 32'(m_held != 0 || m_rec != 0));
      chk(prog_start == (m_ps != 0), "prog_start", 32'(prog_start), 32'(m_ps));
      chk(erase_start == (m_es != 0), "erase_start", 32'(erase_start), 32'(m_es));
      chk(id_word == exp_id(m_mode, rd_addr), "id_word",
          32'(id_word), 32'(exp_id(m_mode, rd_addr)));
      if (m_ps != 0) begin
        chk(32'(prog_addr) == m_paddr, "prog_addr", 32'(prog_addr), m_paddr);
        chk(32'(prog_data) == m_pdata, "prog_data", 32'(prog_data), m_pdata);
      end
      if (m_es != 0) begin
        chk(erase_chip == (m_chip != 0), "erase_chip", 32'(erase_chip), 32'(m_chip));
        chk(32'(erase_addr) == m_eaddr, "erase_addr", 32'(erase_addr), m_eaddr);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
      summary();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [15:0] dt);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = ad; wr_data = dt;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic unlock();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
  endtask

  task automatic hw_pulse(input int n);
    @(negedge clk); #1; hw_rst_n = 0;
    repeat (n) @(negedge clk);
    #1; hw_rst_n = 1;
  endtask

  initial begin
    idle(3);
    @(negedge clk); #1; rst_n = 1;
    ph = "R11"; idle(3);

    ph = "R1"; unlock(); wr(20'h00555, 16'h00A0); wr(20'h12345, 16'h5A3C);
    idle(P_PROG + 3);

    ph = "R4"; wr(20'h00555, 16'hC3AA); wr(20'h002AA, 16'h7E55);
    wr(20'h00555, 16'h12A0); wr(20'h0ABCD, 16'hBEEF); idle(P_PROG + 3);

    ph = "R2"; unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h34000, 16'h0030); idle(P_SECT + 3);
    unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h00555, 16'h0010); idle(P_CHIP + 3);

    ph = "R5"; unlock(); wr(20'h00555, 16'h0090);
    rd_addr = 20'd0; idle(2); rd_addr = 20'd1; idle(2);
    rd_addr = 20'd2; idle(2); rd_addr = 20'd0;

    ph = "R7"; unlock(); wr(20'h00555, 16'h00F0); idle(2);

    ph = "R6"; unlock(); wr(20'h00555, 16'h0098); idle(2);
    ph = "R7"; wr(20'h01234, 16'h00F0); idle(2);

    ph = "R3"; unlock(); wr(20'h00555, 16'h0090); idle(1);
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0011); idle(2);
    wr(20'h00100, 16'h0042); idle(1);
    unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h00777, 16'h0010); idle(3);

    ph = "R8"; unlock(); wr(20'h00555, 16'h0090);
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h00042, 16'h1111);
    wr(20'h00000, 16'h00F0);
    unlock(); wr(20'h00555, 16'h00F0); idle(P_PROG + 3);

    ph = "R9"; unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h50000, 16'h0030);
    hw_pulse(P_RMIN - 1); idle(2);
    hw_pulse(P_RMIN + 2);

    ph = "R10"; wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055);
    wr(20'h00555, 16'h0090); idle(P_SECT + 3);

    ph = "R5"; unlock(); wr(20'h00555, 16'h0090);
    rd_addr = 20'd1; idle(2);
    ph = "R9"; hw_pulse(P_RMIN); idle(P_REC + 3);

    summary();
  end

endmodule